// File: doc/BRIEF.md
# Correlating Global-History Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps a table of small saturating counters and a short shift register holding the outcomes of the most recently resolved branches, regardless of which branch produced them. When a branch is looked up, the history value selects one bank of counters and the low bits of the branch address select a row inside that bank. The top bit of the chosen counter is the prediction.

A fetch stage presents a branch address on the lookup port and reads the taken or not-taken answer in the same cycle. When the branch resolves, the execute stage presents its address and actual outcome on the training port with a valid strobe. The counter that the current history and that address select moves one step toward the outcome. On the same edge the outcome is shifted into the history. Entries carry no address tag, so branches whose low address bits match share a counter. The default build has two history bits, two-bit counters and 256 rows, giving 1,024 counters. With zero history bits the block becomes a plain address-indexed counter table.

Top module: `corr_bpred`

## Requirements
- R1: After reset every counter holds the weakly not-taken value (binary 01 for two-bit counters), so every lookup predicts not taken, and the history register is all zeros.
- R2: The prediction is the most significant bit of the counter at table index {history, pc[ROW_BITS-1:0]}: the history forms the upper index bits and the address row the lower bits. Address bits at ROW_BITS and above are ignored, so addresses that agree in their low ROW_BITS bits share counters.
- R3: A valid update with outcome taken raises the selected counter by one. A valid update with outcome not taken lowers it by one. A counter at 11 therefore needs two not-taken updates in a row before its prediction flips.
- R4: Counters saturate: taken at the maximum (11) leaves it at 11, and not taken at 00 leaves it at 00.
- R5: A valid update selects its counter with the history from before that update. On the same edge the outcome (1 = taken) enters history bit 0, the older bits move up one place and the oldest bit is dropped.
- R6: A valid update changes exactly one counter. Counters of other rows and of other history banks keep their values.
- R7: While the update strobe is low, neither the counters nor the history change, whatever the other update inputs carry.
- R8: The prediction is combinational from the present table state. When a lookup and an update hit the same counter in one cycle, the lookup returns the value from before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| pred_pc | input | PC_W | Address of the branch being looked up |
| pred_taken | output | 1 | Prediction for pred_pc: 1 taken, 0 not taken |
| upd_valid | input | 1 | Strobe: apply a resolved branch outcome this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome: 1 taken, 0 not taken |

## Verification
The assertions assume that reset is held for at least one rising edge before use. They also assume that the update inputs carry known 0/1 values whenever the strobe is high, because the history and saturation checks compare the counter and history state against those inputs. The bench drives every input from defined values on the falling edge. It holds the strobe low during reset and starts each phase from a fresh reset or from a state that its own model tracks. The addresses it uses include upper bits that vary, so aliasing is exercised within the same input ranges.

// File: rtl/corr_bpred_pkg.sv
package corr_bpred_pkg;

  // Widest counter supported by the step helper.
  localparam int unsigned CTR_MAX_W = 8;

  // One saturating step of a counter whose largest code is `top`.
  function automatic logic [CTR_MAX_W-1:0] sat_step(
    input logic [CTR_MAX_W-1:0] cur,
    input logic [CTR_MAX_W-1:0] top,
    input logic                 up
  );
    logic [CTR_MAX_W-1:0] res;
    if (up) res = (cur == top)   ? cur : cur + 1'b1;
    else    res = (cur == '0)    ? cur : cur - 1'b1;
    return res;
  endfunction

endpackage

// File: rtl/bp_hist_reg.sv
module bp_hist_reg #(
  parameter int unsigned HIST_BITS = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 shift_en,
  input  logic                 bit_in,
  output logic [HIST_BITS-1:0] hist
);

  logic [HIST_BITS-1:0] hist_q;

  always_ff @(posedge clk) begin
    if (rst)           hist_q <= '0;
    else if (shift_en) hist_q <= HIST_BITS'({hist_q, bit_in});
  end

  assign hist = hist_q;

  // Idle cycles leave the history untouched.
  assert_hist_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(hist_q));

  // The newest outcome lands in bit 0.
  assert_hist_newest_R5: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> (hist_q[0] == $past(bit_in)));

endmodule

// File: rtl/bp_ctr_table.sv
module bp_ctr_table
  import corr_bpred_pkg::*;
#(
  parameter int unsigned IDX_W = 10,
  parameter int unsigned CTR_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [CTR_W-1:0] rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);

  localparam int unsigned    DEPTH   = 1 << IDX_W;
  localparam logic [CTR_W-1:0] CTR_TOP = '1;
  localparam logic [CTR_W-1:0] WEAK_NT = CTR_W'((1 << (CTR_W - 1)) - 1);

  logic [CTR_W-1:0] mem [DEPTH];
  logic [CTR_W-1:0] wr_cur;
  logic [CTR_W-1:0] wr_nxt;

  assign wr_cur = mem[wr_idx];
  assign wr_nxt = CTR_W'(sat_step(CTR_MAX_W'(wr_cur), CTR_MAX_W'(CTR_TOP), wr_taken));
  assign rd_ctr = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= WEAK_NT;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_nxt;
    end
  end

  always_comb begin
    if (!rst && wr_en) begin
      // Counter moves by at most one code per training event.
      assert_ctr_step_R3: assert ((wr_nxt == wr_cur) || (wr_nxt == wr_cur + 1'b1) ||
                                  (wr_nxt == wr_cur - 1'b1))
        else $error("counter jumped from %0d to %0d", wr_cur, wr_nxt);
      // Ends of the range hold.
      assert_ctr_sat_R4: assert (!((wr_cur == CTR_TOP && wr_taken) || (wr_cur == '0 && !wr_taken))
                                 || (wr_nxt == wr_cur))
        else $error("counter left its bound at %0d", wr_cur);
    end
  end

endmodule

// File: rtl/corr_bpred.sv
module corr_bpred #(
  parameter int unsigned PC_W      = 32,
  parameter int unsigned ROW_BITS  = 8,
  parameter int unsigned HIST_BITS = 2,
  parameter int unsigned CTR_BITS  = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] pred_pc,
  output logic            pred_taken,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken
);

  localparam int unsigned IDX_W = HIST_BITS + ROW_BITS;

  logic [ROW_BITS-1:0] pred_row;
  logic [ROW_BITS-1:0] upd_row;
  logic [IDX_W-1:0]    pred_idx;
  logic [IDX_W-1:0]    upd_idx;
  logic [CTR_BITS-1:0] pred_ctr;

  assign pred_row = pred_pc[ROW_BITS-1:0];
  assign upd_row  = upd_pc[ROW_BITS-1:0];

  generate
    if (PC_W > ROW_BITS) begin : g_hi_pc
      logic unused_hi_pc;
      assign unused_hi_pc = ^{pred_pc[PC_W-1:ROW_BITS], upd_pc[PC_W-1:ROW_BITS]};
    end

    if (HIST_BITS > 0) begin : g_corr
      logic [HIST_BITS-1:0] ghist;

      bp_hist_reg #(.HIST_BITS(HIST_BITS)) u_hist (
        .clk     (clk),
        .rst     (rst),
        .shift_en(upd_valid),
        .bit_in  (upd_taken),
        .hist    (ghist)
      );

      assign pred_idx = {ghist, pred_row};
      assign upd_idx  = {ghist, upd_row};
    end else begin : g_plain
      assign pred_idx = pred_row;
      assign upd_idx  = upd_row;
    end
  endgenerate

  bp_ctr_table #(.IDX_W(IDX_W), .CTR_W(CTR_BITS)) u_table (
    .clk     (clk),
    .rst     (rst),
    .rd_idx  (pred_idx),
    .rd_ctr  (pred_ctr),
    .wr_en   (upd_valid),
    .wr_idx  (upd_idx),
    .wr_taken(upd_taken)
  );

  assign pred_taken = pred_ctr[CTR_BITS-1];

  // First cycle out of reset: every lookup says not taken.
  assert_reset_nt_R1: assert property (@(posedge clk)
    $fell(rst) |-> !pred_taken);

endmodule

// File: tb/corr_bpred_tb.sv
module corr_bpred_tb;

  localparam int CLK_P = 10;
  localparam int PC_W  = 32;
  localparam int ROWS  = 256;
  localparam int BANKS = 4;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [PC_W-1:0] pred_pc = '0;
  logic            pred_taken;
  logic            upd_valid = 1'b0;
  logic [PC_W-1:0] upd_pc = '0;
  logic            upd_taken = 1'b0;

  int n_cmp  = 0;
  int n_bad  = 0;
  bit done   = 1'b0;

  int model [BANKS*ROWS];
  int hist;
  int unsigned seed = 32'h1234_5678;

  always #(CLK_P/2) clk = ~clk;

  corr_bpred u_dut (
    .clk       (clk),
    .rst       (rst),
    .pred_pc   (pred_pc),
    .pred_taken(pred_taken),
    .upd_valid (upd_valid),
    .upd_pc    (upd_pc),
    .upd_taken (upd_taken)
  );

  function automatic int idx_of(input logic [PC_W-1:0] pc);
    return hist * ROWS + int'(pc[7:0]);
  endfunction

  function automatic int unsigned rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < BANKS*ROWS; i++) model[i] = 1;
    hist = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; upd_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  // One cycle: drive lookup and update, compare the lookup, advance the model.
  task automatic step(input logic [PC_W-1:0] ppc, input logic v,
                      input logic [PC_W-1:0] upc, input logic t, input string tag);
    bit exp;
    int k;
    @(negedge clk);
    pred_pc = ppc; upd_valid = v; upd_pc = upc; upd_taken = t;
    #1;
    exp = (model[idx_of(ppc)] >= 2);
    n_cmp++;
    if (pred_taken !== exp) begin
      n_bad++;
      $display("FAIL %s pc=%h hist=%0d actual=%b expected=%b", tag, ppc, hist, pred_taken, exp);
    end
    if (v) begin
      k = idx_of(upc);
      if (t) model[k] = (model[k] == 3) ? 3 : model[k] + 1;
      else   model[k] = (model[k] == 0) ? 0 : model[k] - 1;
      hist = ((hist << 1) | int'(t)) & (BANKS - 1);
    end
  endtask

  task automatic sweep_rows(input logic [23:0] hi, input string tag);
    for (int r = 0; r < ROWS; r++) step({hi, 8'(r)}, 1'b0, '0, 1'b0, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    model_reset();
    do_reset();

    // R1: all rows predict not taken after reset, history zero.
    sweep_rows(24'h0, "R1");

    // R3/R4: same-direction training on one row; history reaches 11 and stays.
    for (int i = 0; i < 6; i++) step(32'h3, 1'b1, 32'h3, 1'b1, "R3_R4_up");
    // R8: lookup and update on the same counter; checks pre-update value.
    for (int i = 0; i < 4; i++) step(32'h3, 1'b1, 32'h3, 1'b1, "R8");
    // R3: two not-taken outcomes from the strong end (history moves banks).
    for (int i = 0; i < 6; i++) step(32'h3, 1'b1, 32'h3, 1'b0, "R3_down");
    // R4: not taken at the floor with history pinned at 00.
    for (int i = 0; i < 5; i++) step(32'h9, 1'b1, 32'h9, 1'b0, "R4_floor");

    // R2: aliasing by upper address bits.
    for (int k = 0; k < 8; k++) step({24'(k * 37 + 1), 8'h03}, 1'b0, '0, 1'b0, "R2_alias");

    // R5: alternating outcomes hop between banks 01 and 10.
    for (int i = 0; i < 12; i++) step(32'h40, 1'b1, 32'h40, 1'(i & 1), "R5");

    // R7: strobe low with live-looking inputs changes nothing.
    for (int i = 0; i < 20; i++) step(32'h40 + 32'(i % 3), 1'b0, 32'h40, 1'b1, "R7");
    sweep_rows(24'hABCDE, "R7_R6");

    // R6: train one row hard, then confirm every other row in current bank.
    for (int i = 0; i < 8; i++) step(32'h7F, 1'b1, 32'h7F, 1'b1, "R6_train");
    sweep_rows(24'h1, "R6");

    // Exhaustive bank coverage: visit each history value and sweep every row.
    for (int b = 0; b < BANKS; b++) begin
      step(32'h0, 1'b1, 32'h11, 1'(b >> 1), "R5_bank");
      step(32'h0, 1'b1, 32'h11, 1'(b & 1), "R5_bank");
      sweep_rows(24'(b), "R2_bank");
    end

    // Pseudo-random traffic on a small set of rows with random upper bits.
    for (int i = 0; i < 4000; i++) begin
      int unsigned a = rnd();
      int unsigned c = rnd();
      logic [PC_W-1:0] up = {c[31:8], 5'b0, a[2:0]};
      logic [PC_W-1:0] pp = a[3] ? up : {a[31:8], 5'b0, c[2:0]};
      step(pp, a[4] | a[5], up, c[1] ^ c[0] ^ a[6], "R2_R3_R5_R8_rand");
    end

    // R1: reset again mid-run clears everything.
    do_reset();
    for (int b = 0; b < 1; b++) sweep_rows(24'h7, "R1_rerun");

    finish_run();
  end

endmodule